// File: doc/BRIEF.md
# External Interrupt Aggregator with Cascade Output

This block gathers 64 interrupt inputs and folds them into one cascade interrupt toward a host. Software reaches it through a 32-bit register port that uses word addresses inside a 4 KB window. Each input has two configuration words. The first holds a two-bit enable and a four-bit sense code. The second holds an eight-bit tag that software normally sets to the source number.

Most inputs are plain active-high level sources. Inputs 47 to 50 are different: they can also sense active-low levels, rising edges and falling edges. An edge is latched as pending, and it stays pending until software issues a clear command that names that input.

A global detection enable gates every input. A status word reports in its top byte the lowest-numbered input that is both enabled and pending. The code 63 in that byte means nothing is pending.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the cascade output is low, the status word reads 0x3F000000, the detection enable reads 0, and every configuration word reads 0.
- R2: The first configuration word of source n sits at byte offset 0x200 + 8·n. Bits 29:28 of it hold the enable and bits 27:24 hold the sense code. Its other bits read as 0.
- R3: A source can be reported only while both of its enable bits are 1. A source with only one enable bit set is never reported.
- R4: Every source outside 47..50 behaves as active-high level, whatever its sense code holds.
- R5: On sources 47..50 the sense code selects the mode: 0x0 is active-low level, 0x1 is active-high level, 0x2 is falling edge and 0x3 is rising edge. Any other code behaves as active-high level.
- R6: An edge source stays pending after its input returns to rest. It is cleared only by a write to byte offset 0x0C0 that has bit 8 set and carries the source number modulo 16 in bits 3:0. A write with bit 8 clear, or one naming another number, leaves it pending.
- R7: The status word at byte offset 0x144 returns, in bits 31:24, the lowest-numbered source that is enabled and pending, with all other bits 0. It returns 63 when no source qualifies, and source 63 is never reported. Writes to this word are ignored.
- R8: Bit 0 of the word at byte offset 0x004 is the detection enable. While it is 0, no source is pending and no edge is latched.
- R9: The cascade output is high exactly when the status byte holds a code other than 63. Both update one clock after their inputs change.
- R10: Bits 7:0 of the second configuration word (first word + 4) hold a stored tag. Its other bits read as 0.
- R11: The level-mask word at byte offset 0x084 holds all 32 bits, and bit 0 of the word at byte offset 0x444 is stored. Both are storage only. The clear command word reads 0. Any offset not named here reads 0 and ignores writes.
- R12: Read data appears on the clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt inputs, synchronous to clk |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 10 | Word address (byte offset bits 11:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Cascade interrupt toward the host |

## Verification
The bench checks that an edge survives the return of its input to rest, and that clear commands without bit 8 or naming another source do not remove it. A design that decoded the clear number loosely would lose pending edges here. It also checks that edges arriving while detection is off are never latched; a design that latched them would raise a stale interrupt when detection is turned on again. Priority is probed with several sources pending at once, including a half-enabled source and source 63. A wrong encoder would report the wrong number or report the reserved code as a real interrupt. Sources outside the edge-capable set are given the active-low and edge codes, to show that the sense field has no effect on them.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 8;

  localparam logic [AW-1:0] A_DET   = 10'h001;
  localparam logic [AW-1:0] A_LMASK = 10'h021;
  localparam logic [AW-1:0] A_ECLR  = 10'h030;
  localparam logic [AW-1:0] A_STAT  = 10'h051;
  localparam logic [AW-1:0] A_PKT   = 10'h111;
  localparam logic [AW-1:0] A_CFG   = 10'h080;

  localparam logic [3:0] SNS_LOW  = 4'h0;
  localparam logic [3:0] SNS_HIGH = 4'h1;
  localparam logic [3:0] SNS_FALL = 4'h2;
  localparam logic [3:0] SNS_RISE = 4'h3;
endpackage

// File: rtl/xirq_src.sv
module xirq_src
  import xirq_pkg::*;
#(
  parameter bit EDGE_OK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [5:0] a_fld,
  input  logic [7:0] b_fld,
  input  logic       sig_i,
  input  logic       det_en_i,
  input  logic       clr_i,
  output logic       pend_o,
  output logic [5:0] a_q_o,
  output logic [7:0] b_q_o
);
  logic [1:0] en_q, en_d;
  logic [3:0] sns_q, sns_d;
  logic [7:0] tag_q, tag_d;
  logic       act;

  always_comb begin
    en_d  = en_q;
    sns_d = sns_q;
    tag_d = tag_q;
    if (wr_a) {en_d, sns_d} = a_fld;
    if (wr_b) tag_d = b_fld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sns_q <= '0;
      tag_q <= '0;
    end else begin
      en_q  <= en_d;
      sns_q <= sns_d;
      tag_q <= tag_d;
    end
  end

  generate
    if (EDGE_OK) begin : g_edge
      logic prev_q, edg_q, edg_d, is_edge, hit;

      always_comb begin
        is_edge = (sns_q == SNS_RISE) || (sns_q == SNS_FALL);
        hit     = (sns_q == SNS_RISE) ? (sig_i & ~prev_q) : (~sig_i & prev_q);
        edg_d   = edg_q;
        if (clr_i) edg_d = 1'b0;
        if (det_en_i && is_edge && hit) edg_d = 1'b1;
        case (sns_q)
          SNS_LOW:            act = ~sig_i;
          SNS_RISE, SNS_FALL: act = edg_q;
          default:            act = sig_i;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          edg_q  <= 1'b0;
        end else begin
          prev_q <= sig_i;
          edg_q  <= edg_d;
        end
      end
    end else begin : g_lvl
      logic unused_bits;
      assign unused_bits = ^{clr_i, sns_q};
      assign act = sig_i;
    end
  endgenerate

  assign pend_o = det_en_i & (&en_q) & act;
  assign a_q_o  = {en_q, sns_q};
  assign b_q_o  = tag_q;
endmodule

// File: rtl/xirq_pick.sv
module xirq_pick #(
  parameter int unsigned N    = 64,
  parameter int unsigned NONE = 63,
  parameter int unsigned IW   = 8
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = IW'(NONE);
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && (i != int'(NONE))) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int unsigned N_SRC     = 64,
  parameter int unsigned EDGE_LO   = 47,
  parameter int unsigned EDGE_HI   = 50,
  parameter int unsigned NONE_CODE = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq_o
);
  localparam int unsigned SW     = $clog2(N_SRC);
  localparam int unsigned CFG_WD = 2 * N_SRC;

  logic          det_q, det_d;
  logic [DW-1:0] lmask_q, lmask_d;
  logic          pkt_q, pkt_d;
  logic [CW-1:0] win_q, win_d;
  logic          irq_q, irq_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          eclr;

  logic [AW-1:0] cfg_off;
  logic          in_cfg;
  logic [SW-1:0] src_sel;
  logic          half;

  logic [N_SRC-1:0] pend;
  logic [5:0]       a_q [N_SRC];
  logic [7:0]       b_q [N_SRC];
  logic             any;

  assign cfg_off = addr - A_CFG;
  assign in_cfg  = (addr >= A_CFG) && (32'(addr) < 32'(A_CFG) + CFG_WD);
  assign src_sel = cfg_off[SW:1];
  assign half    = cfg_off[0];

  // global register next state
  always_comb begin
    det_d   = det_q;
    lmask_d = lmask_q;
    pkt_d   = pkt_q;
    eclr    = 1'b0;
    if (wr_en) begin
      case (addr)
        A_DET:   det_d   = wdata[0];
        A_LMASK: lmask_d = wdata;
        A_PKT:   pkt_d   = wdata[0];
        A_ECLR:  eclr    = wdata[8];
        default: ;
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_src
      logic wa, wb, hit;
      assign wa  = wr_en & in_cfg & ~half & (src_sel == SW'(gi));
      assign wb  = wr_en & in_cfg &  half & (src_sel == SW'(gi));
      assign hit = eclr & (wdata[3:0] == 4'(gi % 16));
      xirq_src #(
        .EDGE_OK((gi >= EDGE_LO) && (gi <= EDGE_HI))
      ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_a     (wa),
        .wr_b     (wb),
        .a_fld    (wdata[29:24]),
        .b_fld    (wdata[7:0]),
        .sig_i    (src_i[gi]),
        .det_en_i (det_q),
        .clr_i    (hit),
        .pend_o   (pend[gi]),
        .a_q_o    (a_q[gi]),
        .b_q_o    (b_q[gi])
      );
    end
  endgenerate

  xirq_pick #(
    .N    (N_SRC),
    .NONE (NONE_CODE),
    .IW   (CW)
  ) u_pick (
    .req   (pend),
    .idx_o (win_d),
    .any_o (any)
  );

  assign irq_d = any;

  // read mux
  always_comb begin
    rd_d = '0;
    if (in_cfg) begin
      if (half) rd_d = {24'b0, b_q[src_sel]};
      else      rd_d = {2'b0, a_q[src_sel], 24'b0};
    end else begin
      case (addr)
        A_DET:   rd_d = {31'b0, det_q};
        A_LMASK: rd_d = lmask_q;
        A_PKT:   rd_d = {31'b0, pkt_q};
        A_STAT:  rd_d = {win_q, 24'b0};
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q   <= 1'b0;
      lmask_q <= '0;
      pkt_q   <= 1'b0;
      win_q   <= CW'(NONE_CODE);
      irq_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      det_q   <= det_d;
      lmask_q <= lmask_d;
      pkt_q   <= pkt_d;
      win_q   <= win_d;
      irq_q   <= irq_d;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk #(
  parameter int unsigned CW        = 8,
  parameter int unsigned NONE_CODE = 63
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [31:0]   rdata,
  input logic          irq_o,
  input logic          det_q,
  input logic [CW-1:0] win_q
);
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  a_r8_det_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !det_q |=> !irq_o);

  a_r9_irq_tracks_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (win_q != CW'(NONE_CODE)));

  a_r7_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= CW'(NONE_CODE));
endmodule

bind xirq_ctrl xirq_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .rd_en (rd_en),
  .rdata (rdata),
  .irq_o (irq_o),
  .det_q (det_q),
  .win_q (win_q)
);

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xirq_ctrl u_xirq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // {word address, write value, expected readback}
  localparam logic [73:0] VT [0:10] = '{
    {10'h001, 32'hFFFF_FFFF, 32'h0000_0001},
    {10'h021, 32'h1234_5678, 32'h1234_5678},
    {10'h111, 32'hFFFF_FFFF, 32'h0000_0001},
    {10'h080, 32'hFFFF_FFFF, 32'h3F00_0000},
    {10'h081, 32'hABCD_EF5A, 32'h0000_005A},
    {10'h0FE, 32'h3000_0000, 32'h3000_0000},
    {10'h0FF, 32'h0000_003F, 32'h0000_003F},
    {10'h030, 32'h0000_01FF, 32'h0000_0000},
    {10'h040, 32'hFFFF_FFFF, 32'h0000_0000},
    {10'h3FF, 32'hDEAD_BEEF, 32'h0000_0000},
    {10'h051, 32'h0000_0000, 32'h3F00_0000}
  };

  function automatic logic [9:0] cfga(int n);
    return 10'(128 + 2 * n);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_stat(string req, int src, logic exp_irq);
    logic [31:0] v;
    settle();
    chk(irq_o == exp_irq, req, 32'(irq_o), 32'(exp_irq));
    do_rd(10'h051, v);
    chk(v == {8'(src), 24'b0}, req, v, {8'(src), 24'b0});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // table walk: R2 R8 R10 R11 R7 write then read back
    for (int i = 0; i < 11; i++) begin
      do_wr(VT[i][73:64], VT[i][63:32]);
      do_rd(VT[i][73:64], v);
      chk(v == VT[i][31:0], $sformatf("R2/R7/R8/R10/R11 row %0d", i), v, VT[i][31:0]);
    end

    // R1 reset state
    do_reset();
    chk(irq_o == 1'b0, "R1 irq", 32'(irq_o), 0);
    do_rd(10'h051, v);
    chk(v == 32'h3F00_0000, "R1 status", v, 32'h3F00_0000);
    do_rd(10'h001, v);
    chk(v == 0, "R1 det", v, 0);
    do_rd(cfga(5), v);
    chk(v == 0, "R1 cfg", v, 0);

    // R4: level source with low/edge sense codes still active high
    do_wr(10'h001, 32'h1);
    do_wr(cfga(10), 32'h3000_0000);
    chk_stat("R4 idle", 63, 1'b0);
    src_i[10] = 1'b1;
    chk_stat("R4 high", 10, 1'b1);
    do_wr(cfga(10), 32'h3300_0000);
    src_i[10] = 1'b0;
    chk_stat("R4 edge code no latch", 63, 1'b0);
    src_i[10] = 1'b1;
    chk_stat("R4 edge code level", 10, 1'b1);

    // R3 half enable; R7 priority
    do_wr(cfga(5), 32'h1000_0000);
    src_i[5] = 1'b1;
    chk_stat("R3 half enable", 10, 1'b1);
    do_wr(cfga(5), 32'h3100_0000);
    chk_stat("R7 lowest wins", 5, 1'b1);
    do_wr(cfga(63), 32'h3100_0000);
    src_i[63] = 1'b1;
    src_i[5] = 1'b0;
    src_i[10] = 1'b0;
    chk_stat("R7 source 63 never reported", 63, 1'b0);
    src_i[63] = 1'b0;

    // R8 detection gate
    src_i[10] = 1'b1;
    do_wr(10'h001, 32'h0);
    chk_stat("R8 det off", 63, 1'b0);
    do_wr(10'h001, 32'h1);
    chk_stat("R9 det on", 10, 1'b1);
    src_i[10] = 1'b0;

    // R5/R6 rising edge on 48
    do_wr(cfga(48), 32'h3300_0000);
    src_i[48] = 1'b1;
    chk_stat("R5 rise", 48, 1'b1);
    src_i[48] = 1'b0;
    chk_stat("R6 held", 48, 1'b1);
    do_wr(10'h030, 32'h0000_0000);
    chk_stat("R6 no bit8", 48, 1'b1);
    do_wr(10'h030, 32'h0000_0101);
    chk_stat("R6 other source", 48, 1'b1);
    do_wr(10'h030, 32'h0000_0100);
    chk_stat("R6 cleared", 63, 1'b0);

    // R5/R6 falling edge on 47 (clear code 15)
    do_wr(cfga(47), 32'h3200_0000);
    src_i[47] = 1'b1;
    chk_stat("R5 fall rise ignored", 63, 1'b0);
    src_i[47] = 1'b0;
    chk_stat("R5 fall", 47, 1'b1);
    do_wr(10'h030, 32'h0000_010F);
    chk_stat("R6 clear 47", 63, 1'b0);

    // R5 level low on 50
    do_wr(cfga(50), 32'h3000_0000);
    chk_stat("R5 level low", 50, 1'b1);
    src_i[50] = 1'b1;
    chk_stat("R5 level low inactive", 63, 1'b0);

    // R8: edge while detection off not latched
    do_wr(10'h001, 32'h0);
    src_i[48] = 1'b1;
    settle();
    src_i[48] = 1'b0;
    do_wr(10'h001, 32'h1);
    chk_stat("R8 edge while off", 63, 1'b0);

    // R12 read data holds
    do_rd(10'h021, v);
    chk(v == 0, "R12 read", v, 0);
    do_wr(10'h021, 32'h0000_00AA);
    settle();
    chk(rdata == 0, "R12 hold", rdata, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule